// File: doc/BRIEF.md
# Asynchronous Flash Write-Cycle Sequencer

This block sits on the host side of a parallel NOR-style flash bus and turns single write requests into correctly timed bus write cycles. A requester offers an address, a data word and a mode flag over a valid/ready handshake. The sequencer then drives the active-low chip-enable, write-enable, output-enable and address-valid strobes, together with the address and data buses, so that every minimum interval the memory needs is met. Each interval is given in nanoseconds and converted at elaboration time into whole clock cycles of the parameterised clock period. The conversion always rounds up, so a nonzero interval never becomes zero cycles.

Two mode settings exist. A plain write ends with a write-enable high recovery. A status-affecting command write stretches the recovery so that a status read that follows it sees the longer turnaround. A second request line, held by a burst-read engine, prepares the bus for a synchronous burst read. Chip enable must go high and then low again after the last write-enable rise, and the engine may start its clock only once a minimum gap has passed. The sequencer signals that moment with a one-cycle hand-off pulse. After reset, no write is started until both the reset recovery window and the program-voltage setup window have passed.

Top module: `flash_wr_seq`

## Requirements
- R1: While reset is low, and after it is released, req_ready stays low and fl_ce_n, fl_we_n, fl_adv_n and fl_oe_n stay high. req_ready first goes high after exactly BOOT cycles have passed since release, where BOOT = max(ceil(T_RST_REC_NS/P), ceil(T_VPP_SETUP_NS/P)) and P = CLK_PERIOD_NS.
- R2: A write is accepted on the clock edge where req_valid and req_ready are both high. On the next edge fl_ce_n and fl_adv_n go low while fl_we_n stays high, so chip enable leads write enable by one cycle. fl_adv_n stays low until write enable rises.
- R3: fl_we_n stays low for exactly L cycles, where L = max(ceil(T_WE_LOW_NS/P), ceil(T_ADDR_SETUP_NS/P) - 1, 1).
- R4: fl_addr and fl_data carry the accepted values from the fall of chip enable until it rises. Chip enable rises exactly one cycle after write enable rises.
- R5: fl_we_n is low only while fl_ce_n is low, and fl_oe_n stays high throughout every write and preparation.
- R6: After a plain write (req_cmd = 0), req_ready returns high exactly 1 + H cycles after write enable rises, where H = max(ceil(T_WE_HIGH_NS/P), 1). req_ready is low for the whole cycle.
- R7: After a status-affecting write (req_cmd = 1), req_ready returns high exactly 1 + max(H, ceil(T_STAT_TURN_NS/P)) cycles after write enable rises.
- R8: fl_vpp_en and fl_wp_n are high from the first clock edge after reset release and stay high. The first write-enable fall comes at least ceil(T_RST_REC_NS/P) cycles after release, and the first rise at least ceil(T_VPP_SETUP_NS/P) cycles after release.
- R9: When sync_req is held in the idle state, chip enable falls no sooner than ceil(T_SYNC_CE_NS/P) cycles after the last write-enable rise. Chip enable is always high for at least one cycle before this fall.
- R10: During burst preparation, fl_ce_n is low and burst_go rises in the first cycle that is at least ceil(T_SYNC_CLK_NS/P) - 1 cycles after the last write-enable rise. This gives a preparation length of max(1, G - (entry edge - rise edge)) cycles, where G = ceil(T_SYNC_CLK_NS/P). On the next edge chip enable goes high and the block is idle again.
- R11: If req_valid and sync_req are both high in idle, the write is taken first. It runs with fl_adv_n low and burst_go low, and the preparation follows once the write has recovered.
- R12: Each conversion rounds up. For example, 42 ns at a 5 ns period gives 9 cycles and 32 ns gives 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_PERIOD_NS |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_cmd | input | 1 | 1 = status-affecting command write, 0 = plain write |
| sync_req | input | 1 | Level, held until burst_go: prepare for a synchronous burst read |
| burst_go | output | 1 | One-cycle hand-off: the burst clock may start after this cycle |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low (held high) |
| fl_adv_n | output | 1 | Flash address-valid strobe, active low |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_data | output | DATA_W | Flash data bus, driven |
| fl_vpp_en | output | 1 | Program-voltage enable |
| fl_wp_n | output | 1 | Write-protect release, active low protect |

## Verification
The assertions assume that reset is held low for at least one clock. They also assume that sync_req, once raised, stays high until burst_go is seen, and that the clock really has the period given by CLK_PERIOD_NS. Nothing else may drive the flash strobes while the sequencer owns them. The stimulus changes inputs only on falling clock edges. It raises sync_req only from idle and drops it on the burst_go cycle, and it withdraws req_valid as soon as acceptance is seen. The bench overrides the pulse, turnaround and burst-gap values with ones that a 5 ns period does not divide. This makes rounding up visible and makes plain and command recoveries differ in length.

// File: rtl/flash_wr_pkg.sv
// Package: shared types and elaboration-time helpers for the flash write
// sequencer. Assumes every interval is a non-negative nanosecond count.
package flash_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WE_LOW,
        ST_WE_HOLD,
        ST_RECOVER,
        ST_SYNC_PREP
    } fws_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic adv_n;
    } fws_strobe_t;

    // Nanoseconds to cycles, rounding up; nonzero input never yields zero.
    function automatic int fws_ns2cyc(input int ns, input int period_ns);
        return (ns <= 0) ? 0 : (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int fws_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Strobe levels belonging to each state.
    function automatic fws_strobe_t fws_decode(input fws_state_e s);
        fws_strobe_t o;
        o = '{ce_n: 1'b1, we_n: 1'b1, adv_n: 1'b1};
        case (s)
            ST_SETUP:     o = '{ce_n: 1'b0, we_n: 1'b1, adv_n: 1'b0};
            ST_WE_LOW:    o = '{ce_n: 1'b0, we_n: 1'b0, adv_n: 1'b0};
            ST_WE_HOLD:   o = '{ce_n: 1'b0, we_n: 1'b1, adv_n: 1'b1};
            ST_SYNC_PREP: o = '{ce_n: 1'b0, we_n: 1'b1, adv_n: 1'b1};
            default:      o = '{ce_n: 1'b1, we_n: 1'b1, adv_n: 1'b1};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/fws_interval_timer.sv
// Loadable down-counter. A load of N makes expired rise after N cycles,
// counting the first cycle after the load. Assumes N >= 1.
module fws_interval_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Count down toward zero, reloading on request.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (load)            cnt <= load_val - 1'b1;
        else if (cnt != '0)       cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    assert_load_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/fws_boot_guard.sv
// Counts cycles after reset release and raises done once LIMIT cycles have
// passed; done then stays high until the next reset.
module fws_boot_guard #(
    parameter int LIMIT = 40
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Advance until the limit, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (!done) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == CW'(LIMIT));

    assert_done_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

endmodule

// File: rtl/fws_since_counter.sv
// Saturating count of whole cycles since the last restart pulse. It starts
// saturated, meaning no write-enable rise has happened yet.
module fws_since_counter #(
    parameter int SAT = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         restart,
    output logic [$clog2(SAT+1)-1:0]     count
);
    localparam int CW = $clog2(SAT + 1);

    // Restart at zero on the pulse, otherwise climb until saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)                   count <= CW'(SAT);
        else if (restart)             count <= '0;
        else if (count != CW'(SAT))   count <= count + 1'b1;
    end

    assert_since_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(SAT));

endmodule

// File: rtl/flash_wr_seq.sv
// Top: write-cycle sequencer for an asynchronous flash bus. It accepts one
// write at a time, generates the chip/write/address strobes with registered
// outputs, enforces reset/voltage setup, high-time and status turnaround,
// and prepares chip enable for a following synchronous burst read.
// Assumes clk runs at CLK_PERIOD_NS and that sync_req is held until burst_go.
module flash_wr_seq
    import flash_wr_pkg::*;
#(
    parameter int ADDR_W          = 8,
    parameter int DATA_W          = 16,
    parameter int CLK_PERIOD_NS   = 5,
    parameter int T_RST_REC_NS    = 150,
    parameter int T_WE_LOW_NS     = 40,
    parameter int T_ADDR_SETUP_NS = 40,
    parameter int T_WE_HIGH_NS    = 20,
    parameter int T_STAT_TURN_NS  = 20,
    parameter int T_VPP_SETUP_NS  = 200,
    parameter int T_SYNC_CE_NS    = 9,
    parameter int T_SYNC_CLK_NS   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_cmd,
    input  logic              sync_req,
    output logic              burst_go,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n,
    output logic              fl_adv_n,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_data,
    output logic              fl_vpp_en,
    output logic              fl_wp_n
);
    localparam int P          = CLK_PERIOD_NS;
    localparam int RST_CYC    = fws_ns2cyc(T_RST_REC_NS, P);
    localparam int VPP_CYC    = fws_ns2cyc(T_VPP_SETUP_NS, P);
    localparam int BOOT_CYC   = fws_max(fws_max(RST_CYC, VPP_CYC), 1);
    localparam int LOW_CYC    = fws_max(fws_max(fws_ns2cyc(T_WE_LOW_NS, P),
                                        fws_ns2cyc(T_ADDR_SETUP_NS, P) - 1), 1);
    localparam int HIGH_CYC   = fws_max(fws_ns2cyc(T_WE_HIGH_NS, P), 1);
    localparam int REC_CMD    = fws_max(HIGH_CYC, fws_ns2cyc(T_STAT_TURN_NS, P));
    localparam int CE_GAP     = fws_ns2cyc(T_SYNC_CE_NS, P);
    localparam int CLK_GAP    = fws_ns2cyc(T_SYNC_CLK_NS, P);
    localparam int SAT        = fws_max(fws_max(CE_GAP, CLK_GAP), 1);
    localparam int TMR_W      = $clog2(fws_max(LOW_CYC, REC_CMD) + 1);
    localparam int SINCE_W    = $clog2(SAT + 1);

    fws_state_e        state, state_nx;
    fws_strobe_t       strobe_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              cmd_q;
    logic              vpp_q;
    logic              boot_done;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              we_rise;
    logic              accept;
    logic [SINCE_W-1:0] since_we;
    logic              ce_gap_ok;

    fws_boot_guard #(.LIMIT(BOOT_CYC)) u_boot (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (boot_done)
    );

    fws_interval_timer #(.CNT_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    fws_since_counter #(.SAT(SAT)) u_since (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (we_rise),
        .count   (since_we)
    );

    assign ce_gap_ok = (int'(since_we) + 1) >= CE_GAP;
    assign burst_go  = (state == ST_SYNC_PREP) && (int'(since_we) >= CLK_GAP - 1);
    assign req_ready = (state == ST_IDLE) && boot_done;
    assign accept    = req_ready && req_valid;
    assign we_rise   = (state == ST_WE_LOW) && tmr_expired;

    // Next-state and timer-load decision.
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state)
            ST_IDLE: begin
                if (accept)
                    state_nx = ST_SETUP;
                else if (boot_done && sync_req && ce_gap_ok)
                    state_nx = ST_SYNC_PREP;
            end
            ST_SETUP: begin
                state_nx = ST_WE_LOW;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(LOW_CYC);
            end
            ST_WE_LOW: begin
                if (tmr_expired) state_nx = ST_WE_HOLD;
            end
            ST_WE_HOLD: begin
                state_nx = ST_RECOVER;
                tmr_load = 1'b1;
                tmr_val  = cmd_q ? TMR_W'(REC_CMD) : TMR_W'(HIGH_CYC);
            end
            ST_RECOVER: begin
                if (tmr_expired) state_nx = ST_IDLE;
            end
            ST_SYNC_PREP: begin
                if (burst_go) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State and registered strobe outputs, updated together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            strobe_q <= '{ce_n: 1'b1, we_n: 1'b1, adv_n: 1'b1};
        end else begin
            state    <= state_nx;
            strobe_q <= fws_decode(state_nx);
        end
    end

    // Capture the request fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            cmd_q  <= 1'b0;
        end else if (accept) begin
            addr_q <= req_addr;
            data_q <= req_data;
            cmd_q  <= req_cmd;
        end
    end

    // Program-voltage and write-protect release become valid after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) vpp_q <= 1'b0;
        else        vpp_q <= 1'b1;
    end

    assign fl_ce_n   = strobe_q.ce_n;
    assign fl_we_n   = strobe_q.we_n;
    assign fl_adv_n  = strobe_q.adv_n;
    assign fl_oe_n   = 1'b1;
    assign fl_addr   = addr_q;
    assign fl_data   = data_q;
    assign fl_vpp_en = vpp_q;
    assign fl_wp_n   = vpp_q;

    assert_we_inside_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> !fl_ce_n);

    assert_ce_leads_we_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_we_n) |-> ($past(fl_ce_n) == 1'b0));

    assert_bus_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_ce_n && !$past(fl_ce_n)) |-> ($stable(fl_addr) && $stable(fl_data)));

    assert_idle_strobes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (fl_ce_n && fl_we_n));

    assert_vpp_before_we_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (fl_vpp_en && fl_wp_n));

    assert_sync_ce_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fl_ce_n) && fl_adv_n) |-> (int'(since_we) >= CE_GAP));

    assert_handoff_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        burst_go |=> fl_ce_n);

endmodule

// File: tb/sim_flash_wr_seq.sv
`timescale 1ns/1ps
module sim_flash_wr_seq;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int P  = 5;
    localparam int N_RST = 150, N_LOW = 42, N_SET = 40, N_HIGH = 20;
    localparam int N_STAT = 32, N_VPP = 200, N_SCE = 9, N_SCLK = 48;

    function automatic int cdiv(input int ns);
        return (ns <= 0) ? 0 : (ns + P - 1) / P;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_RST  = cdiv(N_RST);
    localparam int E_VPP  = cdiv(N_VPP);
    localparam int E_BOOT = mx(E_RST, E_VPP);
    localparam int E_LOW  = mx(mx(cdiv(N_LOW), cdiv(N_SET) - 1), 1);
    localparam int E_HIGH = mx(cdiv(N_HIGH), 1);
    localparam int E_RCMD = mx(E_HIGH, cdiv(N_STAT));
    localparam int E_CEG  = cdiv(N_SCE);
    localparam int E_CLKG = cdiv(N_SCLK);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_cmd = 1'b0, sync_req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic req_ready, burst_go, fl_ce_n, fl_we_n, fl_oe_n, fl_adv_n, fl_vpp_en, fl_wp_n;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_data;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int r0 = 0;
    int last_rise = -1;
    int first_fall = -1;
    bit finished = 0;

    flash_wr_seq #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(P),
        .T_RST_REC_NS(N_RST), .T_WE_LOW_NS(N_LOW), .T_ADDR_SETUP_NS(N_SET),
        .T_WE_HIGH_NS(N_HIGH), .T_STAT_TURN_NS(N_STAT), .T_VPP_SETUP_NS(N_VPP),
        .T_SYNC_CE_NS(N_SCE), .T_SYNC_CLK_NS(N_SCLK)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_cmd(req_cmd),
        .sync_req(sync_req), .burst_go(burst_go), .fl_ce_n(fl_ce_n),
        .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_adv_n(fl_adv_n),
        .fl_addr(fl_addr), .fl_data(fl_data), .fl_vpp_en(fl_vpp_en), .fl_wp_n(fl_wp_n)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // One write; starts and ends on a falling edge with req_ready high.
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic cmd, input bit with_sync);
        int n;
        int m;
        bit bus_ok;
        req_addr = a; req_data = d; req_cmd = cmd; req_valid = 1'b1;
        if (with_sync) sync_req = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!fl_ce_n && fl_we_n && !fl_adv_n, "R2 setup strobes",
            {fl_ce_n, fl_we_n, fl_adv_n}, 3'b010);
        chk(fl_addr == a && fl_data == d, "R4 bus at ce fall", fl_addr, a);
        if (with_sync) chk(!burst_go && !fl_adv_n, "R11 write wins over sync", burst_go, 0);
        @(negedge clk);
        if (first_fall < 0) first_fall = cyc;
        n = 0;
        bus_ok = 1;
        while (!fl_we_n && n < 1000) begin
            if (fl_ce_n || fl_adv_n || !fl_oe_n || fl_addr != a || fl_data != d) bus_ok = 0;
            n++;
            @(negedge clk);
        end
        chk(n == E_LOW, "R3 we low width", n, E_LOW);
        chk(bus_ok, "R5 ce/oe/adv/bus during we low", 0, 1);
        last_rise = cyc;
        chk(!fl_ce_n && fl_addr == a && fl_data == d, "R4 hold cycle", fl_ce_n, 0);
        m = 1;
        @(negedge clk);
        chk(fl_ce_n, "R4 ce rises one cycle after we", fl_ce_n, 1);
        while (!req_ready && m < 1000) begin
            m++;
            @(negedge clk);
        end
        if (cmd) chk(m == 1 + E_RCMD, "R7 command recovery", m, 1 + E_RCMD);
        else     chk(m == 1 + E_HIGH, "R6 plain recovery", m, 1 + E_HIGH);
    endtask

    // Burst preparation; starts on a falling edge in idle.
    task automatic do_sync();
        int s;
        int k;
        int expk;
        sync_req = 1'b1;
        while (fl_ce_n) @(negedge clk);
        s = cyc;
        if (last_rise >= 0)
            chk(s - last_rise >= E_CEG, "R9 ce fall gap after we rise", s - last_rise, E_CEG);
        chk(fl_we_n && fl_adv_n && fl_oe_n, "R5 prep strobes", fl_we_n, 1);
        k = 1;
        while (!burst_go && k < 1000) begin
            @(negedge clk);
            k++;
        end
        expk = (last_rise < 0) ? 1 : mx(1, E_CLKG - (s - last_rise));
        chk(k == expk, "R10 prep length", k, expk);
        if (last_rise >= 0)
            chk(cyc + 1 - last_rise >= E_CLKG, "R10 clock gap", cyc + 1 - last_rise, E_CLKG);
        sync_req = 1'b0;
        @(negedge clk);
        chk(fl_ce_n && !burst_go && req_ready, "R10 return to idle", fl_ce_n, 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog R1..: run hung actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        int n;
        repeat (4) @(negedge clk);
        chk(!req_ready && fl_ce_n && fl_we_n && fl_adv_n && fl_oe_n && !burst_go,
            "R1 reset state", req_ready, 0);
        rst_n = 1'b1;
        r0 = cyc;
        n = 0;
        while (n < 1000) begin
            @(negedge clk);
            n++;
            if (n == 1) chk(fl_vpp_en && fl_wp_n, "R8 vpp/wp after release", fl_vpp_en, 1);
            if (req_ready) break;
            if (!fl_ce_n || !fl_we_n) chk(0, "R1 strobes idle during boot", 0, 1);
        end
        chk(n == E_BOOT, "R1 boot window", n, E_BOOT);
        // R12: rounding of non-divisible intervals.
        chk(E_LOW == 9 && E_RCMD == 7, "R12 round-up conversion", E_LOW, 9);
        do_write(8'h5A, 16'hC3A5, 1'b0, 0);
        chk(first_fall - r0 >= E_RST, "R8 reset recovery", first_fall - r0, E_RST);
        chk(last_rise - r0 >= E_VPP, "R8 vpp setup", last_rise - r0, E_VPP);
        do_sync();
        do_write(8'h11, 16'h0F0F, 1'b1, 0);
        do_sync();
        do_write(8'hA0, 16'h8001, 1'b0, 1);
        do_sync();
        do_write(8'hA1, 16'h7FFE, 1'b1, 1);
        do_sync();
        for (int i = 0; i < 256; i++) begin
            do_write(i[AW-1:0], 16'(i * 16'h9E37 ^ 16'h1234), 1'(i % 3 == 0), 0);
            if (i % 64 == 5) do_sync();
        end
        chk(fl_vpp_en && fl_wp_n, "R8 vpp/wp still valid", fl_vpp_en, 1);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule